// File: doc/BRIEF.md
# eFuse Auto-Read Timing Sequencer

This block reads a one-time-programmable fuse array one byte at a time. It is driven entirely from a small 32-bit register bus. Software first programs a start offset and an active length, both in clock cycles, for each of the five fuse-macro control pins. It then clears the manual-mode bit and writes a launch command that carries a fuse address. From that point a cycle counter runs on its own. Each control pin is asserted while the counter lies inside its programmed window. The fuse output byte is captured when the strobe window closes, and a completion flag is raised once the last window has ended.

The control pins are chip select (active low), program enable (active low), load, address valid and strobe. Two sets of five timing registers are kept. The read set drives the sequence. The program set is only stored and read back, because burning fuses is not part of this block. The array holds 64 bytes. A launch with an address beyond the array completes normally and returns zero. The default read timing finishes in under 80 cycles, which is well inside a 2 µs polling delay at 50 MHz.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset the registers read as follows. Mode (0x00) reads 1, which is manual mode. Finish status (0x18), data (0x20), launch control (0x24) and every timing register read 0. Revision (0x50) reads 32'h0000_0102. Unmapped offsets read 0. Chip select and program enable are high, and load, address valid and strobe are low.
- R2: The ten timing registers sit at 0x28 to 0x4C, four bytes apart, with the start offset in bits [31:16] and the length in bits [15:0]. Each reads back the last value written to it.
- R3: A read is launched by a write to 0x24 with bit 0 (enable) and bit 1 (read) both set and the fuse address in bits [25:16], provided mode bit 0 is clear and no read is running. The launch takes effect at the clock edge that accepts the write, and the run counter k is 0 in the following cycle.
- R4: The read-set registers are ordered chip select 0x3C, program enable 0x40, load 0x44, address valid 0x48 and strobe 0x4C. Program enable, load, address valid and strobe are each asserted exactly for start <= k < start+length.
- R5: With a nonzero length, chip select is low only for start <= k < start+length. With length 0, it is low for every k from 0 to T, where T is the largest start+length among the read-set registers.
- R6: A read-set length of 0 keeps program enable, load, address valid and strobe inactive for the whole run.
- R7: The data register reads the captured fuse byte in bits [7:0] and 0 in bits [31:8]. The byte is sampled at k equal to the strobe's start+length, so the new value is first visible at the next k.
- R8: The finish flag (bit 0 of 0x18) is 0 at k = T+1 and 1 at k = T+2. At the same point, launch-control bit 0 reads 0 and bit 1 keeps its value. Outside a run all pins are inactive. Writing 1 to bit 0 of 0x18 clears the flag.
- R9: A launch with an address of 64 or more completes with the same timing and sets the finish flag, and the data register then reads 0.
- R10: A launch-control write during a run is ignored. The fuse address output and the launch-control readback are unchanged, and no second run follows.
- R11: While mode bit 0 is set, a launch-control write is ignored. No run starts and the launch-control register stays 0.
- R12: The program-set registers (0x28 to 0x38) are stored and read back but have no effect on the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| fuse_sel_n_o | output | 1 | Fuse macro chip select, active low |
| fuse_prog_n_o | output | 1 | Fuse macro program enable, active low |
| fuse_load_o | output | 1 | Fuse macro load |
| fuse_aen_o | output | 1 | Fuse macro address valid |
| fuse_strobe_o | output | 1 | Fuse macro strobe |
| fuse_a_o | output | 10 | Fuse byte address held for the current read |
| fuse_q_i | input | 8 | Fuse macro output byte |

## Verification
A fault in the run counter or the state machine appears at the pins within the first window. A pin rises at the wrong k, holds for the wrong number of cycles, or the finish flag arrives one or more cycles away from T+2. Each of these is seen on the read that contains the fault. A wrong capture point or a bad range guard shows up in the data register one cycle after the strobe closes. Busy-state leaks show up as a changed address output or a second finish flag inside the next hundred cycles.

// File: rtl/efuse_seq_pkg.sv
`timescale 1ns/1ps
package efuse_seq_pkg;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned ADDR_W = 10;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned N_PIN  = 5;
  localparam int unsigned N_TIM = 2 * N_PIN;

  localparam int PIN_SEL  = 0;
  localparam int PIN_PROG = 1;
  localparam int PIN_LOAD = 2;
  localparam int PIN_AEN  = 3;
  localparam int PIN_STB  = 4;

  localparam logic [7:0] OFS_MODE     = 8'h00;
  localparam logic [7:0] OFS_IRQ      = 8'h18;
  localparam logic [7:0] OFS_DOUT     = 8'h20;
  localparam logic [7:0] OFS_AUTO     = 8'h24;
  localparam logic [7:0] OFS_TIM0     = 8'h28;
  localparam logic [7:0] OFS_TIM_LAST = 8'(OFS_TIM0 + 4 * (N_TIM - 1));
  localparam logic [7:0] OFS_REV      = 8'h50;

  typedef struct packed {
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] len;
  } win_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_st_e;

  function automatic logic [CNT_W:0] win_end(input win_t w);
    return {1'b0, w.start} + {1'b0, w.len};
  endfunction
endpackage

// File: rtl/efuse_pin_win.sv
`timescale 1ns/1ps
module efuse_pin_win
  import efuse_seq_pkg::*;
#(
  parameter bit HOLD_IF_ZERO = 1'b0
) (
  input  logic           run_i,
  input  logic [CNT_W:0] cnt_i,
  input  win_t           win_i,
  output logic           on_o
);
  logic [CNT_W:0] lo, hi;
  assign lo = {1'b0, win_i.start};
  assign hi = win_end(win_i);

  always_comb begin
    if (!run_i)                 on_o = 1'b0;
    else if (win_i.len == '0)   on_o = HOLD_IF_ZERO;
    else                        on_o = (cnt_i >= lo) && (cnt_i < hi);
  end
endmodule

// File: rtl/efuse_regfile.sv
`timescale 1ns/1ps
module efuse_regfile
  import efuse_seq_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0000_0102
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    we_i,
  output logic [31:0]             rdata_o,
  input  logic                    busy_i,
  input  logic                    cap_vld_i,
  input  logic [DATA_W-1:0]       cap_data_i,
  input  logic                    done_i,
  output logic                    launch_o,
  output logic [ADDR_W-1:0]       fuse_addr_o,
  output win_t [N_PIN-1:0]        rd_win_o,
  output logic                    user_mode_o,
  output logic                    irq_o,
  output logic [DATA_W-1:0]       dout_o
);
  logic                mode_q, irq_q, auto_en_q, auto_rd_q;
  logic [ADDR_W-1:0]   auto_addr_q;
  logic [DATA_W-1:0]   dout_q;
  win_t                tim_q [N_TIM];

  logic       tim_hit, auto_acc;
  logic [7:0] tim_off;
  logic [3:0] tim_idx;

  assign tim_off  = addr_i - OFS_TIM0;
  assign tim_idx  = tim_off[5:2];
  assign tim_hit  = (addr_i >= OFS_TIM0) && (addr_i <= OFS_TIM_LAST) && (addr_i[1:0] == 2'b00);
  assign auto_acc = we_i && (addr_i == OFS_AUTO) && !busy_i && !mode_q;
  assign launch_o = auto_acc && wdata_i[0] && wdata_i[1];

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     tim_q[g] <= '0;
      else if (we_i && tim_hit && tim_idx == 4'(g))    tim_q[g] <= wdata_i;
    end
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_rd
    assign rd_win_o[p] = tim_q[N_PIN + p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b1;
      irq_q       <= 1'b0;
      auto_en_q   <= 1'b0;
      auto_rd_q   <= 1'b0;
      auto_addr_q <= '0;
      dout_q      <= '0;
    end else begin
      if (we_i && addr_i == OFS_MODE) mode_q <= wdata_i[0];
      // set wins over a same-cycle clear
      if (done_i)                                         irq_q <= 1'b1;
      else if (we_i && addr_i == OFS_IRQ && wdata_i[0])   irq_q <= 1'b0;
      if (auto_acc) begin
        auto_en_q   <= wdata_i[0];
        auto_rd_q   <= wdata_i[1];
        auto_addr_q <= wdata_i[16 +: ADDR_W];
      end else if (done_i) begin
        auto_en_q   <= 1'b0;
      end
      if (cap_vld_i) dout_q <= cap_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (tim_hit) begin
      rdata_o = tim_q[tim_idx];
    end else begin
      case (addr_i)
        OFS_MODE: rdata_o = {31'b0, mode_q};
        OFS_IRQ:  rdata_o = {31'b0, irq_q};
        OFS_DOUT: rdata_o = {{(32-DATA_W){1'b0}}, dout_q};
        OFS_AUTO: rdata_o = {{(16-ADDR_W){1'b0}}, auto_addr_q, 14'b0, auto_rd_q, auto_en_q};
        OFS_REV:  rdata_o = REV_ID;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign fuse_addr_o = auto_addr_q;
  assign user_mode_o = mode_q;
  assign irq_o       = irq_q;
  assign dout_o      = dout_q;
endmodule

// File: rtl/efuse_rd_seq.sv
`timescale 1ns/1ps
module efuse_rd_seq
  import efuse_seq_pkg::*;
#(
  parameter int unsigned FUSE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  win_t [N_PIN-1:0]  rd_win_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] fuse_q_i,
  output logic              busy_o,
  output logic              run_o,
  output logic [CNT_W:0]    cnt_o,
  output logic              cap_vld_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              done_o
);
  localparam logic [ADDR_W:0] ADDR_LIM = (ADDR_W + 1)'(FUSE_BYTES);

  seq_st_e        st_q;
  logic [CNT_W:0] cnt_q, end_cnt, stb_end;

  always_comb begin
    end_cnt = '0;
    for (int i = 0; i < N_PIN; i++) begin
      if (win_end(rd_win_i[i]) > end_cnt) end_cnt = win_end(rd_win_i[i]);
    end
  end
  assign stb_end = win_end(rd_win_i[PIN_STB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          if (cnt_q == end_cnt) st_q  <= ST_DONE;
          else                  cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign run_o      = (st_q == ST_RUN);
  assign done_o     = (st_q == ST_DONE);
  assign cnt_o      = cnt_q;
  assign cap_vld_o  = run_o && (cnt_q == stb_end);
  assign cap_data_o = ({1'b0, addr_i} < ADDR_LIM) ? fuse_q_i : '0;
endmodule

// File: rtl/efuse_rd_ctrl.sv
`timescale 1ns/1ps
module efuse_rd_ctrl
  import efuse_seq_pkg::*;
#(
  parameter int unsigned FUSE_BYTES = 64,
  parameter logic [31:0] REV_ID     = 32'h0000_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  output logic              fuse_sel_n_o,
  output logic              fuse_prog_n_o,
  output logic              fuse_load_o,
  output logic              fuse_aen_o,
  output logic              fuse_strobe_o,
  output logic [ADDR_W-1:0] fuse_a_o,
  input  logic [DATA_W-1:0] fuse_q_i
);
  logic              seq_busy, seq_run, seq_done, launch, cap_vld;
  logic              user_mode, irq_flag;
  logic [DATA_W-1:0] cap_data, dout_val;
  logic [CNT_W:0]    run_cnt;
  logic [ADDR_W-1:0] rd_addr;
  win_t [N_PIN-1:0]  rd_win;
  logic [N_PIN-1:0]  pin_on;

  efuse_regfile #(.REV_ID(REV_ID)) u_regs (
    .clk_i, .rst_ni,
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .we_i        (reg_we_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (seq_busy),
    .cap_vld_i   (cap_vld),
    .cap_data_i  (cap_data),
    .done_i      (seq_done),
    .launch_o    (launch),
    .fuse_addr_o (rd_addr),
    .rd_win_o    (rd_win),
    .user_mode_o (user_mode),
    .irq_o       (irq_flag),
    .dout_o      (dout_val)
  );

  efuse_rd_seq #(.FUSE_BYTES(FUSE_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .launch_i   (launch),
    .rd_win_i   (rd_win),
    .addr_i     (rd_addr),
    .fuse_q_i   (fuse_q_i),
    .busy_o     (seq_busy),
    .run_o      (seq_run),
    .cnt_o      (run_cnt),
    .cap_vld_o  (cap_vld),
    .cap_data_o (cap_data),
    .done_o     (seq_done)
  );

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    efuse_pin_win #(.HOLD_IF_ZERO(g == PIN_SEL)) u_win (
      .run_i (seq_run),
      .cnt_i (run_cnt),
      .win_i (rd_win[g]),
      .on_o  (pin_on[g])
    );
  end

  assign fuse_sel_n_o  = ~pin_on[PIN_SEL];
  assign fuse_prog_n_o = ~pin_on[PIN_PROG];
  assign fuse_load_o   =  pin_on[PIN_LOAD];
  assign fuse_aen_o    =  pin_on[PIN_AEN];
  assign fuse_strobe_o =  pin_on[PIN_STB];
  assign fuse_a_o      =  rd_addr;
endmodule

// File: rtl/efuse_rd_ctrl_chk.sv
`timescale 1ns/1ps
module efuse_rd_ctrl_chk
  import efuse_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        reg_addr_i,
  input logic [1:0]        reg_wcmd_i,
  input logic              reg_we_i,
  input logic              busy_i,
  input logic              run_i,
  input logic              user_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] dout_i,
  input logic              sel_n_i,
  input logic              prog_n_i,
  input logic              load_i,
  input logic              aen_i,
  input logic              stb_i,
  input logic [ADDR_W-1:0] fuse_a_i
);
  assert_pins_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (sel_n_i && prog_n_i && !load_i && !aen_i && !stb_i));

  assert_finish_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $fell(busy_i));

  assert_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_AUTO && reg_wcmd_i == 2'b11 && !user_i && !busy_i) |=> run_i);

  assert_user_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_AUTO && user_i && !busy_i) |=> !busy_i);

  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(fuse_a_i));

  assert_capture_in_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_i) |-> $past(run_i));
endmodule

bind efuse_rd_ctrl efuse_rd_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wcmd_i (reg_wdata_i[1:0]),
  .reg_we_i   (reg_we_i),
  .busy_i     (seq_busy),
  .run_i      (seq_run),
  .user_i     (user_mode),
  .irq_i      (irq_flag),
  .dout_i     (dout_val),
  .sel_n_i    (fuse_sel_n_o),
  .prog_n_i   (fuse_prog_n_o),
  .load_i     (fuse_load_o),
  .aen_i      (fuse_aen_o),
  .stb_i      (fuse_strobe_o),
  .fuse_a_i   (fuse_a_o)
);

// File: tb/tb_efuse_rd_ctrl.sv
`timescale 1ns/1ps
module tb_efuse_rd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        sel_n, prog_n, load, aen, stb;
  logic [9:0]  fuse_a;
  logic [7:0]  fuse_q;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  efuse_rd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_rdata_o(reg_rdata),
    .fuse_sel_n_o(sel_n), .fuse_prog_n_o(prog_n), .fuse_load_o(load),
    .fuse_aen_o(aen), .fuse_strobe_o(stb), .fuse_a_o(fuse_a), .fuse_q_i(fuse_q)
  );

  // behavioural fuse content; garbage above the array
  always_comb fuse_q = (fuse_a < 10'd64) ? 8'(fuse_a * 37 + 11) : 8'hA5;

  function automatic logic [31:0] exp_byte(input logic [9:0] a);
    return (a < 10'd64) ? {24'b0, 8'(a * 37 + 11)} : 32'h0;
  endfunction

  typedef struct packed {
    logic [9:0]        a;
    logic [4:0][15:0]  st;   // index: 0 sel,1 prog,2 load,3 aen,4 strobe
    logic [4:0][15:0]  ln;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{a: 10'd5,  st: {16'd27, 16'd24, 16'd15, 16'd0, 16'd0}, ln: {16'd37, 16'd31, 16'd55, 16'd0, 16'd0}},
    '{a: 10'd63, st: {16'd4,  16'd0,  16'd1,  16'd0, 16'd2}, ln: {16'd6,  16'd10, 16'd3,  16'd0, 16'd20}},
    '{a: 10'd64, st: {16'd2,  16'd1,  16'd0,  16'd3, 16'd0}, ln: {16'd1,  16'd1,  16'd0,  16'd2, 16'd0}},
    '{a: 10'd0,  st: {16'd0,  16'd0,  16'd0,  16'd0, 16'd0}, ln: {16'd0,  16'd0,  16'd0,  16'd0, 16'd0}}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] launch_word(input logic [9:0] a);
    return {6'b0, a, 14'b0, 2'b11};
  endfunction

  function automatic logic [4:0] pins_on();
    return {stb, aen, load, ~prog_n, ~sel_n};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int total, ks, first [5], cnt [5];
    logic [31:0] dout_pre, dout_post;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1", "mode", d, 32'h1);
    rd(8'h18, d); chk("R1", "finish", d, 32'h0);
    rd(8'h20, d); chk("R1", "data", d, 32'h0);
    rd(8'h24, d); chk("R1", "launch ctrl", d, 32'h0);
    rd(8'h3C, d); chk("R1", "timing", d, 32'h0);
    rd(8'h50, d); chk("R1", "revision", d, 32'h0000_0102);
    rd(8'h54, d); chk("R1", "unmapped", d, 32'h0);
    chk("R1", "pins", {27'b0, pins_on()}, 32'h0);

    // R11 manual mode blocks launch
    wr(8'h24, launch_word(10'd3));
    repeat (5) @(negedge clk);
    chk("R11", "no run sel_n", {31'b0, sel_n}, 32'h1);
    rd(8'h24, d); chk("R11", "launch ctrl untouched", d, 32'h0);
    rd(8'h18, d); chk("R11", "no finish", d, 32'h0);

    // R2 timing register readback (program set kept nonzero for R12)
    for (int i = 0; i < 10; i++) wr(8'(8'h28 + 4 * i), {16'(i + 1), 16'(200 + 7 * i)});
    for (int i = 0; i < 10; i++) begin
      rd(8'(8'h28 + 4 * i), d);
      chk("R2", "timing readback", d, {16'(i + 1), 16'(200 + 7 * i)});
    end

    wr(8'h00, 32'h0);

    // vector table: R3..R9, R12
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 5; p++) wr(8'(8'h3C + 4 * p), {VECS[r].st[p], VECS[r].ln[p]});
      total = 0;
      for (int p = 0; p < 5; p++)
        if (int'(VECS[r].st[p]) + int'(VECS[r].ln[p]) > total) total = int'(VECS[r].st[p]) + int'(VECS[r].ln[p]);
      ks = int'(VECS[r].st[4]) + int'(VECS[r].ln[4]);
      for (int p = 0; p < 5; p++) begin first[p] = -1; cnt[p] = 0; end
      dout_pre = '0; dout_post = '0;
      wr(8'h24, launch_word(VECS[r].a));
      chk("R3", "fuse address", {22'b0, fuse_a}, {22'b0, VECS[r].a});
      for (int k = 0; k <= total + 2; k++) begin
        #1;
        for (int p = 0; p < 5; p++) if (pins_on()[p]) begin
          if (first[p] < 0) first[p] = k;
          cnt[p]++;
        end
        if (k == ks)     rd(8'h20, dout_pre);
        if (k == ks + 1) rd(8'h20, dout_post);
        if (k == total + 1) begin rd(8'h18, d); chk("R8", "finish before T+2", d, 32'h0); end
        if (k == total + 2) begin rd(8'h18, d); chk("R8", "finish at T+2", d, 32'h1); end
        @(negedge clk);
      end
      if (VECS[r].ln[0] == 16'd0) begin
        chk("R5", "sel first", 32'(first[0]), 32'h0);
        chk("R5", "sel count", 32'(cnt[0]), 32'(total + 1));
      end else begin
        chk("R5", "sel first", 32'(first[0]), 32'(VECS[r].st[0]));
        chk("R5", "sel count", 32'(cnt[0]), 32'(VECS[r].ln[0]));
      end
      for (int p = 1; p < 5; p++) begin
        if (VECS[r].ln[p] == 16'd0) begin
          chk("R6", "zero-length pin count", 32'(cnt[p]), 32'h0);
        end else begin
          chk("R4/R12", "pin first", 32'(first[p]), 32'(VECS[r].st[p]));
          chk("R4/R12", "pin count", 32'(cnt[p]), 32'(VECS[r].ln[p]));
        end
      end
      if (ks + 1 <= total + 2) chk("R7", "data after strobe end", dout_post, exp_byte(VECS[r].a));
      chk("R7", "data before strobe end", dout_pre, (r == 0) ? 32'h0 : exp_byte(VECS[r-1].a));
      rd(8'h20, d); chk(VECS[r].a >= 10'd64 ? "R9" : "R7", "data register", d, exp_byte(VECS[r].a));
      rd(8'h24, d); chk("R8", "enable self-cleared", d, {6'b0, VECS[r].a, 14'b0, 2'b10});
      chk("R8", "pins idle", {27'b0, pins_on()}, 32'h0);
      wr(8'h18, 32'h1);
      rd(8'h18, d); chk("R8", "finish cleared", d, 32'h0);
    end
    rd(8'h2C, d); chk("R12", "program set stored", d, {16'd2, 16'd207});

    // R10 write during a run
    for (int p = 0; p < 5; p++) wr(8'(8'h3C + 4 * p), {VECS[0].st[p], VECS[0].ln[p]});
    wr(8'h24, launch_word(10'd7));
    repeat (10) @(negedge clk);
    wr(8'h24, launch_word(10'd9));
    chk("R10", "address held", {22'b0, fuse_a}, 32'd7);
    rd(8'h24, d); chk("R10", "ctrl unchanged", d, launch_word(10'd7));
    repeat (80) @(negedge clk);
    rd(8'h18, d); chk("R10", "first run finished", d, 32'h1);
    rd(8'h20, d); chk("R10", "data of first address", d, exp_byte(10'd7));
    wr(8'h18, 32'h1);
    repeat (90) @(negedge clk);
    rd(8'h18, d); chk("R10", "no second run", d, 32'h0);
    chk("R10", "sel idle", {31'b0, sel_n}, 32'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule